// File: doc/BRIEF.md
# Bus Match Break Condition Unit

This unit sits beside a processor core and watches its bus traffic. Each cycle it can see one data-bus access (address, data, access size, direction) and one instruction fetch (program counter plus a flag that marks a delay-slot instruction), together with the current address-space identifier. A debug agent programs a small register set through a write-only port. The unit then raises a one-cycle break request when a programmed combination of qualifiers has held for a programmed number of events.

Four qualifiers exist: address, sized data, direction and ASID. Each has its own enable, and a disabled qualifier does not restrict a match. A mode bit points the address comparison either at data accesses or at instruction fetches. An event counter delays the break to the Nth combined match. A break on a delay-slot fetch is held back and raised on the branch-target fetch. After a break the unit stays quiet until it is re-armed.

Register offsets on `cfg_sel`: 0 control, 1 compare address, 2 compare data, 3 compare ASID, 4 event count (low 16 bits), 5 re-arm (any write). Control bits: 0 address enable, 1 fetch mode, 2 data enable, 4:3 data size (0 byte, 1 16-bit word, 2 32-bit longword), 5 direction enable, 6 direction select (1 write cycles, 0 read cycles), 7 ASID enable.

Top module: `bmb_unit`

## Requirements
- R1: After reset `brk_req` is low, every register is zero except the event count, which is 1, and the unit is armed. A first qualifying event after only control and address are programmed therefore breaks.
- R2: In bus mode (control bit 1 = 0) with address enable set, an event with `bus_valid` high and `bus_addr` equal to the compare address raises `brk_req` on the clock edge that samples the event. Any other address does not.
- R3: In fetch mode (control bit 1 = 1) only `fetch_valid` cycles are events and `fetch_pc` is compared instead of `bus_addr`. Data-bus cycles never match, and the data and direction qualifiers are ignored.
- R4: With data enable set, a bus cycle matches only if `bus_size` equals the programmed size and the active byte lanes equal the compare data. Little-endian lanes are used: byte N of the data is bits 8N+7:8N. A byte access uses the lane given by `bus_addr[1:0]`, and a word access uses lanes 0-1 or 2-3 as given by `bus_addr[1]`. Inactive lanes are ignored.
- R5: With direction enable set, control bit 6 = 0 restricts matches to read cycles (`bus_write` = 0) and bit 6 = 1 to write cycles.
- R6: With ASID enable set, a match also needs `cur_asid` equal to the programmed ASID.
- R7: With event count N (0 treated as 1), the break is raised on the Nth combined match after arming, and earlier matches produce none.
- R8: In fetch mode, a final match on a fetch with `fetch_slot` high raises no break at once. The break is raised at the next fetch with `fetch_slot` low.
- R9: A disabled qualifier is always true. With every qualifier that applies to the current mode disabled, the unit never breaks.
- R10: `brk_req` lasts one cycle. Later matches are ignored until a write to offset 5 re-arms the unit, and re-arming reloads the event count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register offset |
| cfg_wdata | input | CFG_W (32) | Register write data |
| bus_valid | input | 1 | Data-bus access present this cycle |
| bus_addr | input | AW (32) | Data-bus access address |
| bus_data | input | DW (32) | Data-bus value, lane aligned |
| bus_size | input | 2 | Access size: 0 byte, 1 word, 2 longword |
| bus_write | input | 1 | 1 for write cycle, 0 for read |
| fetch_valid | input | 1 | Instruction fetch present this cycle |
| fetch_pc | input | AW (32) | Program counter of the fetch |
| fetch_slot | input | 1 | Fetched instruction sits in a delay slot |
| cur_asid | input | ASW (8) | Current address-space identifier |
| brk_req | output | 1 | One-cycle break request |

## Verification
An event sampled at a rising edge shows its result on `brk_req` immediately after that same edge. There is exactly one register between the bus inputs and the output. Register writes take effect at the edge that samples them, so the next event already uses the new values. The bench drives every input at a falling edge and reads `brk_req` at the following falling edge, which is half a cycle after the only edge that can change it. For a deferred delay-slot break, the check is placed on the branch-target fetch, not on the slot fetch.

// File: rtl/bmb_pkg.sv
package bmb_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_QUAD = 2'd3
   } acc_size_e;

   localparam logic [2:0] SEL_CTRL  = 3'd0;
   localparam logic [2:0] SEL_ADDR  = 3'd1;
   localparam logic [2:0] SEL_DATA  = 3'd2;
   localparam logic [2:0] SEL_ASID  = 3'd3;
   localparam logic [2:0] SEL_COUNT = 3'd4;
   localparam logic [2:0] SEL_REARM = 3'd5;

   localparam int CTRL_W = 8;

   // Field order is fixed: software encodes these bit positions.
   typedef struct packed {
      logic      asid_en;
      logic      dir_write;
      logic      dir_en;
      acc_size_e size;
      logic      data_en;
      logic      pc_mode;
      logic      addr_en;
   } ctrl_t;

endpackage

// File: rtl/bmb_regs.sv
module bmb_regs
   import bmb_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int ASW   = 8,
   parameter int CW    = 16,
   parameter int CFG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [2:0]       sel,
   input  logic [CFG_W-1:0] wdata,
   output ctrl_t            ctrl,
   output logic [AW-1:0]    cmp_addr,
   output logic [DW-1:0]    cmp_data,
   output logic [ASW-1:0]   cmp_asid,
   output logic [CW-1:0]    cnt_cfg,
   output logic             rearm
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= '0;
         cmp_addr <= '0;
         cmp_data <= '0;
         cmp_asid <= '0;
         cnt_cfg  <= CW'(1);
      end else if (we) begin
         case (sel)
            SEL_CTRL:  ctrl     <= ctrl_t'(wdata[CTRL_W-1:0]);
            SEL_ADDR:  cmp_addr <= wdata[AW-1:0];
            SEL_DATA:  cmp_data <= wdata[DW-1:0];
            SEL_ASID:  cmp_asid <= wdata[ASW-1:0];
            SEL_COUNT: cnt_cfg  <= wdata[CW-1:0];
            default:   ;
         endcase
      end
   end

   assign rearm = we && (sel == SEL_REARM);

endmodule

// File: rtl/bmb_qualify.sv
module bmb_qualify
   import bmb_pkg::*;
#(
   parameter int AW  = 32,
   parameter int DW  = 32,
   parameter int ASW = 8
) (
   input  ctrl_t          ctrl,
   input  logic [AW-1:0]  cmp_addr,
   input  logic [DW-1:0]  cmp_data,
   input  logic [ASW-1:0] cmp_asid,
   input  logic           bus_valid,
   input  logic [AW-1:0]  bus_addr,
   input  logic [DW-1:0]  bus_data,
   input  logic [1:0]     bus_size,
   input  logic           bus_write,
   input  logic           fetch_valid,
   input  logic [AW-1:0]  fetch_pc,
   input  logic           fetch_slot,
   input  logic [ASW-1:0] cur_asid,
   output logic           hit,
   output logic           hit_slot
);

   localparam int LANES = DW / 8;
   localparam int LB    = $clog2(LANES);

   logic [LANES-1:0] lane_on;
   logic [LANES-1:0] lane_eq;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [LB-1:0] IDX = LB'(i);
      assign lane_on[i] = ((IDX >> bus_size) == (bus_addr[LB-1:0] >> bus_size));
      assign lane_eq[i] = (bus_data[8*i +: 8] == cmp_data[8*i +: 8]);
   end

   logic [AW-1:0] probe_addr;
   logic          event_seen;
   logic          addr_ok, data_ok, dir_ok, asid_ok, any_en;

   always_comb begin
      probe_addr = ctrl.pc_mode ? fetch_pc : bus_addr;
      event_seen = ctrl.pc_mode ? fetch_valid : bus_valid;
      addr_ok    = !ctrl.addr_en || (probe_addr == cmp_addr);
      asid_ok    = !ctrl.asid_en || (cur_asid == cmp_asid);
      if (ctrl.pc_mode) begin
         data_ok = 1'b1;
         dir_ok  = 1'b1;
         any_en  = ctrl.addr_en || ctrl.asid_en;
      end else begin
         data_ok = !ctrl.data_en ||
                   ((bus_size == ctrl.size) && ((lane_on & ~lane_eq) == '0));
         dir_ok  = !ctrl.dir_en || (bus_write == ctrl.dir_write);
         any_en  = ctrl.addr_en || ctrl.data_en || ctrl.dir_en || ctrl.asid_en;
      end
      hit      = event_seen && any_en && addr_ok && data_ok && dir_ok && asid_ok;
      hit_slot = ctrl.pc_mode && fetch_slot;
   end

endmodule

// File: rtl/bmb_sequencer.sv
module bmb_sequencer #(
   parameter int CW        = 16,
   parameter bit USE_COUNT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rearm,
   input  logic [CW-1:0] cnt_cfg,
   input  logic          pc_mode,
   input  logic          hit,
   input  logic          hit_slot,
   input  logic          fetch_valid,
   input  logic          fetch_slot,
   output logic [CW-1:0] remaining,
   output logic          brk
);

   logic          armed;
   logic          pending;
   logic [CW-1:0] left_q;
   logic [CW-1:0] reload;
   logic          final_hit;
   logic          target_fetch;

   assign reload = (cnt_cfg == '0) ? CW'(1) : cnt_cfg;

   if (USE_COUNT) begin : g_counted
      assign final_hit = (left_q <= CW'(1));
   end else begin : g_single
      assign final_hit = 1'b1;
   end

   assign target_fetch = pc_mode && fetch_valid && !fetch_slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b1;
         pending <= 1'b0;
         left_q  <= CW'(1);
         brk     <= 1'b0;
      end else begin
         brk <= 1'b0;
         if (rearm) begin
            armed   <= 1'b1;
            pending <= 1'b0;
            left_q  <= reload;
         end else if (armed) begin
            if (pending) begin
               if (target_fetch) begin
                  brk     <= 1'b1;
                  armed   <= 1'b0;
                  pending <= 1'b0;
               end
            end else if (hit) begin
               if (final_hit) begin
                  if (hit_slot) begin
                     pending <= 1'b1;
                  end else begin
                     brk   <= 1'b1;
                     armed <= 1'b0;
                  end
               end else begin
                  left_q <= left_q - CW'(1);
               end
            end
         end
      end
   end

   assign remaining = left_q;

endmodule

// File: rtl/bmb_unit.sv
module bmb_unit
   import bmb_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int ASW       = 8,
   parameter int CW        = 16,
   parameter int CFG_W     = 32,
   parameter bit USE_COUNT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_sel,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             bus_valid,
   input  logic [AW-1:0]    bus_addr,
   input  logic [DW-1:0]    bus_data,
   input  logic [1:0]       bus_size,
   input  logic             bus_write,
   input  logic             fetch_valid,
   input  logic [AW-1:0]    fetch_pc,
   input  logic             fetch_slot,
   input  logic [ASW-1:0]   cur_asid,
   output logic             brk_req
);

   if (DW != 32 && DW != 64) begin : g_bad_dw
      $error("bmb_unit: DW must be 32 or 64");
   end
   if (AW > CFG_W || DW > CFG_W || ASW > CFG_W || CW > CFG_W) begin : g_bad_cfg
      $error("bmb_unit: a field is wider than the write port");
   end
   if (CW < 1 || ASW < 1 || AW < 4 || CFG_W < CTRL_W) begin : g_bad_min
      $error("bmb_unit: parameter below its minimum");
   end

   ctrl_t          ctrl;
   logic [AW-1:0]  cmp_addr;
   logic [DW-1:0]  cmp_data;
   logic [ASW-1:0] cmp_asid;
   logic [CW-1:0]  cnt_cfg;
   logic [CW-1:0]  remaining;
   logic           rearm;
   logic           hit;
   logic           hit_slot;

   bmb_regs #(.AW(AW), .DW(DW), .ASW(ASW), .CW(CW), .CFG_W(CFG_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .sel      (cfg_sel),
      .wdata    (cfg_wdata),
      .ctrl     (ctrl),
      .cmp_addr (cmp_addr),
      .cmp_data (cmp_data),
      .cmp_asid (cmp_asid),
      .cnt_cfg  (cnt_cfg),
      .rearm    (rearm)
   );

   bmb_qualify #(.AW(AW), .DW(DW), .ASW(ASW)) u_qual (
      .ctrl        (ctrl),
      .cmp_addr    (cmp_addr),
      .cmp_data    (cmp_data),
      .cmp_asid    (cmp_asid),
      .bus_valid   (bus_valid),
      .bus_addr    (bus_addr),
      .bus_data    (bus_data),
      .bus_size    (bus_size),
      .bus_write   (bus_write),
      .fetch_valid (fetch_valid),
      .fetch_pc    (fetch_pc),
      .fetch_slot  (fetch_slot),
      .cur_asid    (cur_asid),
      .hit         (hit),
      .hit_slot    (hit_slot)
   );

   bmb_sequencer #(.CW(CW), .USE_COUNT(USE_COUNT)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .rearm       (rearm),
      .cnt_cfg     (cnt_cfg),
      .pc_mode     (ctrl.pc_mode),
      .hit         (hit),
      .hit_slot    (hit_slot),
      .fetch_valid (fetch_valid),
      .fetch_slot  (fetch_slot),
      .remaining   (remaining),
      .brk         (brk_req)
   );

endmodule

// File: rtl/bmb_unit_chk.sv
module bmb_unit_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          brk_req,
   input logic          bus_valid,
   input logic          fetch_valid,
   input logic          fetch_slot,
   input logic [7:0]    ctrl_bits,
   input logic [CW-1:0] remaining
);

   logic mode_fetch;
   logic some_enabled;

   assign mode_fetch   = ctrl_bits[1];
   assign some_enabled = mode_fetch ? (ctrl_bits[0] | ctrl_bits[7])
                                    : (ctrl_bits[0] | ctrl_bits[2] | ctrl_bits[5] | ctrl_bits[7]);

   // R10: the request never lasts two cycles
   assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req |=> !brk_req);

   // R2: a request always follows a sampled event
   assert_follows_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req |-> $past(bus_valid || fetch_valid));

   // R9: nothing fires when no applicable qualifier was enabled
   assert_none_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req |-> $past(some_enabled));

   // R8: in fetch mode a request is never raised on a delay-slot fetch
   assert_slot_deferred_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_req && $past(mode_fetch)) |-> $past(fetch_valid && !fetch_slot));

   // R7: a request is raised only on the last counted event
   assert_count_exhausted_R7: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req |-> ($past(remaining) <= CW'(1)));

endmodule

bind bmb_unit bmb_unit_chk #(.CW(CW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .brk_req     (brk_req),
   .bus_valid   (bus_valid),
   .fetch_valid (fetch_valid),
   .fetch_slot  (fetch_slot),
   .ctrl_bits   (ctrl),
   .remaining   (remaining)
);

// File: tb/bmb_unit_tb.sv
module bmb_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        bus_valid = 1'b0;
   logic [31:0] bus_addr = '0;
   logic [31:0] bus_data = '0;
   logic [1:0]  bus_size = '0;
   logic        bus_write = 1'b0;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        fetch_slot = 1'b0;
   logic [7:0]  cur_asid = '0;
   logic        brk_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   bmb_unit u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data), .bus_size(bus_size),
      .bus_write(bus_write), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
      .fetch_slot(fetch_slot), .cur_asid(cur_asid), .brk_req(brk_req)
   );

   task automatic check(input logic got, input logic exp, input string req);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: brk_req=%b expected %b", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] d);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rearm();
      wr(3'd5, 32'h0);
   endtask

   task automatic bus_ev(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                         input logic w, input logic exp, input string req);
      bus_valid = 1'b1; bus_addr = a; bus_data = d; bus_size = sz; bus_write = w;
      @(negedge clk);
      bus_valid = 1'b0;
      check(brk_req, exp, req);
   endtask

   task automatic fetch_ev(input logic [31:0] pc, input logic slot, input logic exp,
                           input string req);
      fetch_valid = 1'b1; fetch_pc = pc; fetch_slot = slot;
      @(negedge clk);
      fetch_valid = 1'b0; fetch_slot = 1'b0;
      check(brk_req, exp, req);
   endtask

   task automatic t_reset_R1();
      check(brk_req, 1'b0, "R1 during reset");
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check(brk_req, 1'b0, "R1 after reset");
      wr(3'd1, 32'h100);
      wr(3'd0, 32'h01);
      bus_ev(32'h100, 32'h0, 2'd2, 1'b0, 1'b1, "R1 armed with count 1 from reset");
      bus_ev(32'h100, 32'h0, 2'd2, 1'b0, 1'b0, "R10 no second request");
   endtask

   task automatic t_addr_R2();
      rearm();
      bus_ev(32'h104, 32'h0, 2'd2, 1'b0, 1'b0, "R2 other address");
      bus_ev(32'h100, 32'h5, 2'd2, 1'b1, 1'b1, "R2 address match");
   endtask

   task automatic t_fetch_R3();
      wr(3'd1, 32'h2000);
      wr(3'd0, 32'h03);
      rearm();
      bus_ev(32'h2000, 32'h0, 2'd2, 1'b0, 1'b0, "R3 bus cycle ignored in fetch mode");
      fetch_ev(32'h2004, 1'b0, 1'b0, "R3 other pc");
      fetch_ev(32'h2000, 1'b0, 1'b1, "R3 pc match");
   endtask

   task automatic t_data_R4();
      wr(3'd0, 32'h04);
      wr(3'd2, 32'h0000AB00);
      rearm();
      bus_ev(32'h10, 32'h1234AB78, 2'd1, 1'b0, 1'b0, "R4 size mismatch");
      bus_ev(32'h10, 32'h1234AB78, 2'd0, 1'b0, 1'b0, "R4 byte lane 0 differs");
      bus_ev(32'h11, 32'h1234AB78, 2'd0, 1'b0, 1'b1, "R4 byte lane 1 matches");
      wr(3'd0, 32'h0C);
      wr(3'd2, 32'hBEEF0000);
      rearm();
      bus_ev(32'h0, 32'hBEEF1111, 2'd1, 1'b0, 1'b0, "R4 low word differs");
      bus_ev(32'h2, 32'hBEEF1111, 2'd1, 1'b0, 1'b1, "R4 high word matches");
      wr(3'd0, 32'h14);
      wr(3'd2, 32'hCAFEF00D);
      rearm();
      bus_ev(32'h0, 32'hCAFEF00C, 2'd2, 1'b0, 1'b0, "R4 longword one bit off");
      bus_ev(32'h0, 32'hCAFEF00D, 2'd2, 1'b0, 1'b1, "R4 longword matches");
   endtask

   task automatic t_dir_R5();
      wr(3'd0, 32'h20);
      rearm();
      bus_ev(32'h0, 32'h0, 2'd2, 1'b1, 1'b0, "R5 write rejected in read mode");
      bus_ev(32'h0, 32'h0, 2'd2, 1'b0, 1'b1, "R5 read accepted");
      wr(3'd0, 32'h60);
      rearm();
      bus_ev(32'h0, 32'h0, 2'd2, 1'b0, 1'b0, "R5 read rejected in write mode");
      bus_ev(32'h0, 32'h0, 2'd2, 1'b1, 1'b1, "R5 write accepted");
   endtask

   task automatic t_asid_R6();
      wr(3'd0, 32'h81);
      wr(3'd1, 32'h300);
      wr(3'd3, 32'h5A);
      rearm();
      cur_asid = 8'h11;
      bus_ev(32'h300, 32'h0, 2'd2, 1'b0, 1'b0, "R6 wrong asid");
      cur_asid = 8'h5A;
      bus_ev(32'h300, 32'h0, 2'd2, 1'b0, 1'b1, "R6 asid match");
   endtask

   task automatic t_count_R7();
      wr(3'd0, 32'h01);
      wr(3'd1, 32'h400);
      wr(3'd4, 32'd3);
      rearm();
      bus_ev(32'h400, 32'h0, 2'd2, 1'b0, 1'b0, "R7 first match");
      bus_ev(32'h404, 32'h0, 2'd2, 1'b0, 1'b0, "R7 non match not counted");
      bus_ev(32'h400, 32'h0, 2'd2, 1'b0, 1'b0, "R7 second match");
      bus_ev(32'h400, 32'h0, 2'd2, 1'b0, 1'b1, "R7 third match breaks");
      bus_ev(32'h400, 32'h0, 2'd2, 1'b0, 1'b0, "R10 ignored until re-arm");
      rearm();
      bus_ev(32'h400, 32'h0, 2'd2, 1'b0, 1'b0, "R10 re-arm reloads count");
      bus_ev(32'h400, 32'h0, 2'd2, 1'b0, 1'b0, "R10 reloaded second");
      bus_ev(32'h400, 32'h0, 2'd2, 1'b0, 1'b1, "R10 reloaded third breaks");
      wr(3'd4, 32'd0);
      rearm();
      bus_ev(32'h400, 32'h0, 2'd2, 1'b0, 1'b1, "R7 count zero acts as one");
   endtask

   task automatic t_slot_R8();
      wr(3'd0, 32'h03);
      wr(3'd1, 32'h500);
      rearm();
      fetch_ev(32'h500, 1'b1, 1'b0, "R8 no break on slot");
      fetch_ev(32'h600, 1'b0, 1'b1, "R8 break at branch target");
      fetch_ev(32'h500, 1'b0, 1'b0, "R10 quiet after deferred break");
   endtask

   task automatic t_off_R9();
      wr(3'd0, 32'h00);
      rearm();
      bus_ev(32'h500, 32'h0, 2'd2, 1'b0, 1'b0, "R9 all disabled bus");
      fetch_ev(32'h500, 1'b0, 1'b0, "R9 all disabled fetch");
      wr(3'd0, 32'h01);
      rearm();
      bus_ev(32'h500, 32'hFFFFFFFF, 2'd0, 1'b1, 1'b1, "R9 disabled qualifiers pass");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_R1();
      t_addr_R2();
      t_fetch_R3();
      t_data_R4();
      t_dir_R5();
      t_asid_R6();
      t_count_R7();
      t_slot_R8();
      t_off_R9();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule